// File: doc/BRIEF.md
# Mid-Level Cache Line Coherence Controller

This block keeps the MESI coherence state of each line in a small table for a cache level that sits between a private inner cache and a shared outer level. It accepts three input streams. The inner side sends loads, stores, replacements and recall acknowledgements. The outer side sends invalidates and forwarded read or write requests. Outer responses carry shared data, peer-supplied data, exclusive data and writeback acknowledgements. From these it emits outward requests and acknowledgements, inward data with a class tag, and inward recall requests. Data storage, the networks and the directory are not modelled. Only message kinds and line indices cross the ports.

The central case is a pending shared read that is overtaken by an invalidate. The controller acknowledges the invalidate at once and records a transient state. When the fill arrives, it hands the block inward as stale data, which the inner cache may consume once but must not keep. The line then ends Invalid. Without this path the invalidating writer would wait for an acknowledgement that never comes.

Only one event is processed per cycle. All outputs are registered, so each one appears in the cycle after its event is accepted.

Top module: `mlc_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and no output valid is asserted.
- R2: An inner load (type 0) to an Invalid line emits outward GETS (type 0) for that line and leaves the line pending-shared.
- R3: An outer invalidate (type 0) to a line that is pending-shared, or already pending-shared-and-invalidated, is accepted and answered with INV_ACK (type 3) the next cycle. The line moves to pending-shared-and-invalidated.
- R4: Outer shared data (response type 0) on a pending-shared line delivers class 0 inward and leaves the line Shared. A later inner load to a Shared line returns class 0 with no outward message.
- R5: Outer shared data on a pending-shared-and-invalidated line delivers class 3 (stale) inward and leaves the line Invalid, so the next load emits GETS again.
- R6: Peer shared data (response type 1) emits UNBLOCK (type 4) outward. On a pending-shared line it delivers class 0 and the line ends Shared. On a pending-shared-and-invalidated line it delivers class 3 and the line ends Invalid.
- R7: Exclusive data (response type 2) on either pending-shared state emits EXCL_UNBLOCK (type 5) and delivers class 1, and the line becomes Exclusive. A load hit then returns class 1, and a store hit returns class 1 and makes the line Modified.
- R8: An inner load (0), store (1) or replacement (2) is not accepted (ready low) while its line is in any transient state.
- R9: Outer requests are held back only while their line waits for an inner recall. While the line is pending-shared they are accepted whenever no response is present.
- R10: A store (1) to Invalid emits GETX (type 1). A store to Shared also emits GETX. Exclusive data then emits EXCL_UNBLOCK and delivers class 1 from Invalid, or class 2 (ack) from Shared. Either way the line becomes Modified.
- R11: Replacement (2) of a Modified line emits PUTX (type 2) and blocks inner requests until a writeback ack (response type 3) makes it Invalid. Replacement of a Shared line makes it Invalid silently.
- R12: An invalidate, FWD_GETS (1) or FWD_GETX (2) to a valid line raises an inward recall. Only on the recall acknowledgement (inner type 3) does the outward reply go: INV_ACK then Invalid, DATA (type 6) then Shared, or DATA then Invalid, respectively. An invalidate to an Invalid line is acknowledged directly.
- R13: In one cycle a response wins over an outer request, which wins over an inner request. The losers see ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_req_valid_i | input | 1 | Inner request valid |
| in_req_type_i | input | 2 | 0 load, 1 store, 2 replacement, 3 recall ack |
| in_req_line_i | input | LINE_W | Inner request line index |
| in_req_ready_o | output | 1 | Inner request accepted this cycle |
| ext_req_valid_i | input | 1 | Outer request valid |
| ext_req_type_i | input | 2 | 0 invalidate, 1 forwarded read, 2 forwarded write |
| ext_req_line_i | input | LINE_W | Outer request line index |
| ext_req_ready_o | output | 1 | Outer request accepted this cycle |
| ext_rsp_valid_i | input | 1 | Outer response valid (always taken) |
| ext_rsp_type_i | input | 2 | 0 data, 1 peer data, 2 exclusive data, 3 writeback ack |
| ext_rsp_line_i | input | LINE_W | Outer response line index |
| out_valid_o | output | 1 | Outward message valid |
| out_type_o | output | 3 | 0 GETS, 1 GETX, 2 PUTX, 3 INV_ACK, 4 UNBLOCK, 5 EXCL_UNBLOCK, 6 DATA |
| out_line_o | output | LINE_W | Outward message line |
| in_rsp_valid_o | output | 1 | Inward data message valid |
| in_rsp_class_o | output | 2 | 0 shared, 1 exclusive, 2 ack, 3 stale |
| in_rsp_line_o | output | LINE_W | Inward data line |
| in_recall_valid_o | output | 1 | Inward recall request valid |
| in_recall_line_o | output | LINE_W | Inward recall line |

## Verification
The assertions watch the following on every cycle:
- an invalidate that hits a pending-shared line is acknowledged in the next cycle;
- stale data can only follow a fill into the pending-shared-and-invalidated state;
- exclusive data on a pending-shared line always yields both the unblock and the exclusive class;
- outer requests to a pending-shared line are never held back when no response competes;
- a recall only follows an accepted outer request.

Some behaviours only show up over a sequence of events, and the bench scenarios cover those. Examples are the line ending Invalid after stale delivery, which is seen by a fresh GETS, and the ordering of the recall handshake. The same applies to stalls during writeback and upgrade, and to three-way arbitration within one cycle.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  typedef enum logic [3:0] {
    ST_I, ST_S, ST_E, ST_M,
    ST_IS,    // shared read pending
    ST_IM,    // exclusive read pending
    ST_SM,    // upgrade pending
    ST_ISI,   // shared read pending, invalidated meanwhile
    ST_MI,    // writeback pending
    ST_EVI,   // inner recall, then inv ack -> I
    ST_EVDI,  // inner recall, then data -> I
    ST_EVDS   // inner recall, then data -> S
  } line_st_e;

  typedef enum logic [1:0] {
    IRQ_LOAD = 2'd0, IRQ_STORE = 2'd1, IRQ_REPL = 2'd2, IRQ_RCL_ACK = 2'd3
  } inner_req_e;

  typedef enum logic [1:0] {
    OREQ_INV = 2'd0, OREQ_FWD_GETS = 2'd1, OREQ_FWD_GETX = 2'd2, OREQ_RSVD = 2'd3
  } outer_req_e;

  typedef enum logic [1:0] {
    ORSP_DATA = 2'd0, ORSP_DATA_PEER = 2'd1, ORSP_DATA_EXCL = 2'd2, ORSP_WB_ACK = 2'd3
  } outer_rsp_e;

  typedef enum logic [2:0] {
    OUT_GETS = 3'd0, OUT_GETX = 3'd1, OUT_PUTX = 3'd2, OUT_INV_ACK = 3'd3,
    OUT_UNBLOCK = 3'd4, OUT_EXCL_UNBLOCK = 3'd5, OUT_DATA = 3'd6, OUT_RSVD = 3'd7
  } out_type_e;

  typedef enum logic [1:0] {
    CLS_SHARED = 2'd0, CLS_EXCL = 2'd1, CLS_ACK = 2'd2, CLS_STALE = 2'd3
  } in_class_e;

  typedef enum logic [1:0] {
    EV_NONE, EV_INNER, EV_OREQ, EV_ORSP
  } ev_kind_e;

  function automatic logic is_stable(line_st_e s);
    return (s == ST_I) || (s == ST_S) || (s == ST_E) || (s == ST_M);
  endfunction

  function automatic logic is_evict(line_st_e s);
    return (s == ST_EVI) || (s == ST_EVDI) || (s == ST_EVDS);
  endfunction

endpackage

// File: rtl/mlc_state_table.sv
module mlc_state_table
  import mlc_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LINE_W-1:0] waddr_i,
  input  line_st_e          wdata_i,
  input  logic [LINE_W-1:0] raddr_a_i,
  input  logic [LINE_W-1:0] raddr_b_i,
  input  logic [LINE_W-1:0] raddr_c_i,
  output line_st_e          rdata_a_o,
  output line_st_e          rdata_b_o,
  output line_st_e          rdata_c_o
);
  localparam int NumLines = 1 << LINE_W;

  line_st_e st_arr [NumLines];

  for (genvar g = 0; g < NumLines; g++) begin : g_line
    line_st_e q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= ST_I;
      else if (we_i && (waddr_i == LINE_W'(g))) q <= wdata_i;
    end
    assign st_arr[g] = q;
  end

  assign rdata_a_o = st_arr[raddr_a_i];
  assign rdata_b_o = st_arr[raddr_b_i];
  assign rdata_c_o = st_arr[raddr_c_i];

endmodule

// File: rtl/mlc_arbiter.sv
module mlc_arbiter
  import mlc_pkg::*;
(
  input  logic     rsp_valid_i,
  input  logic     oreq_valid_i,
  input  line_st_e oreq_st_i,
  input  logic     ireq_valid_i,
  input  logic [1:0] ireq_type_i,
  input  line_st_e ireq_st_i,
  output logic     oreq_ready_o,
  output logic     ireq_ready_o,
  output ev_kind_e kind_o
);
  logic oreq_go, ireq_go, ireq_blocked;

  // outer requests wait only on an inner recall
  assign oreq_ready_o = !rsp_valid_i && !is_evict(oreq_st_i);
  assign oreq_go      = oreq_valid_i && oreq_ready_o;

  assign ireq_blocked = (ireq_type_i != IRQ_RCL_ACK) && !is_stable(ireq_st_i);
  assign ireq_ready_o = !rsp_valid_i && !oreq_go && !ireq_blocked;
  assign ireq_go      = ireq_valid_i && ireq_ready_o;

  always_comb begin
    if (rsp_valid_i)  kind_o = EV_ORSP;
    else if (oreq_go) kind_o = EV_OREQ;
    else if (ireq_go) kind_o = EV_INNER;
    else              kind_o = EV_NONE;
  end

endmodule

// File: rtl/mlc_next.sv
module mlc_next
  import mlc_pkg::*;
(
  input  ev_kind_e   kind_i,
  input  line_st_e   st_i,
  input  logic [1:0] typ_i,
  output line_st_e   nxt_o,
  output logic       out_v_o,
  output out_type_e  out_t_o,
  output logic       inr_v_o,
  output in_class_e  inr_c_o,
  output logic       rcl_v_o
);
  inner_req_e ireq;
  outer_req_e oreq;
  outer_rsp_e orsp;

  assign ireq = inner_req_e'(typ_i);
  assign oreq = outer_req_e'(typ_i);
  assign orsp = outer_rsp_e'(typ_i);

  always_comb begin
    nxt_o   = st_i;
    out_v_o = 1'b0;
    out_t_o = OUT_GETS;
    inr_v_o = 1'b0;
    inr_c_o = CLS_SHARED;
    rcl_v_o = 1'b0;
    case (kind_i)
      EV_INNER: begin
        case (ireq)
          IRQ_LOAD: begin
            case (st_i)
              ST_I: begin out_v_o = 1'b1; out_t_o = OUT_GETS; nxt_o = ST_IS; end
              ST_S: begin inr_v_o = 1'b1; inr_c_o = CLS_SHARED; end
              ST_E, ST_M: begin inr_v_o = 1'b1; inr_c_o = CLS_EXCL; end
              default: ;
            endcase
          end
          IRQ_STORE: begin
            case (st_i)
              ST_I: begin out_v_o = 1'b1; out_t_o = OUT_GETX; nxt_o = ST_IM; end
              ST_S: begin out_v_o = 1'b1; out_t_o = OUT_GETX; nxt_o = ST_SM; end
              ST_E, ST_M: begin inr_v_o = 1'b1; inr_c_o = CLS_EXCL; nxt_o = ST_M; end
              default: ;
            endcase
          end
          IRQ_REPL: begin
            case (st_i)
              ST_S, ST_E: nxt_o = ST_I;
              ST_M: begin out_v_o = 1'b1; out_t_o = OUT_PUTX; nxt_o = ST_MI; end
              default: ;
            endcase
          end
          default: begin  // recall ack
            case (st_i)
              ST_EVI:  begin out_v_o = 1'b1; out_t_o = OUT_INV_ACK; nxt_o = ST_I; end
              ST_EVDI: begin out_v_o = 1'b1; out_t_o = OUT_DATA;    nxt_o = ST_I; end
              ST_EVDS: begin out_v_o = 1'b1; out_t_o = OUT_DATA;    nxt_o = ST_S; end
              default: ;
            endcase
          end
        endcase
      end
      EV_OREQ: begin
        case (oreq)
          OREQ_INV: begin
            case (st_i)
              ST_I, ST_IM, ST_MI: begin out_v_o = 1'b1; out_t_o = OUT_INV_ACK; end
              // ack now; the fill still to come becomes stale
              ST_IS, ST_ISI: begin out_v_o = 1'b1; out_t_o = OUT_INV_ACK; nxt_o = ST_ISI; end
              ST_SM: begin out_v_o = 1'b1; out_t_o = OUT_INV_ACK; nxt_o = ST_IM; end
              ST_S, ST_E, ST_M: begin rcl_v_o = 1'b1; nxt_o = ST_EVI; end
              default: ;
            endcase
          end
          OREQ_FWD_GETS: begin
            case (st_i)
              ST_E, ST_M: begin rcl_v_o = 1'b1; nxt_o = ST_EVDS; end
              ST_MI: begin out_v_o = 1'b1; out_t_o = OUT_DATA; end
              default: ;
            endcase
          end
          OREQ_FWD_GETX: begin
            case (st_i)
              ST_E, ST_M: begin rcl_v_o = 1'b1; nxt_o = ST_EVDI; end
              ST_MI: begin out_v_o = 1'b1; out_t_o = OUT_DATA; end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
      EV_ORSP: begin
        case (orsp)
          ORSP_DATA: begin
            case (st_i)
              ST_IS:  begin inr_v_o = 1'b1; inr_c_o = CLS_SHARED; nxt_o = ST_S; end
              ST_ISI: begin inr_v_o = 1'b1; inr_c_o = CLS_STALE;  nxt_o = ST_I; end
              default: ;
            endcase
          end
          ORSP_DATA_PEER: begin
            case (st_i)
              ST_IS: begin
                out_v_o = 1'b1; out_t_o = OUT_UNBLOCK;
                inr_v_o = 1'b1; inr_c_o = CLS_SHARED; nxt_o = ST_S;
              end
              ST_ISI: begin
                out_v_o = 1'b1; out_t_o = OUT_UNBLOCK;
                inr_v_o = 1'b1; inr_c_o = CLS_STALE; nxt_o = ST_I;
              end
              default: ;
            endcase
          end
          ORSP_DATA_EXCL: begin
            case (st_i)
              ST_IS, ST_ISI: begin
                out_v_o = 1'b1; out_t_o = OUT_EXCL_UNBLOCK;
                inr_v_o = 1'b1; inr_c_o = CLS_EXCL; nxt_o = ST_E;
              end
              ST_IM: begin
                out_v_o = 1'b1; out_t_o = OUT_EXCL_UNBLOCK;
                inr_v_o = 1'b1; inr_c_o = CLS_EXCL; nxt_o = ST_M;
              end
              ST_SM: begin
                out_v_o = 1'b1; out_t_o = OUT_EXCL_UNBLOCK;
                inr_v_o = 1'b1; inr_c_o = CLS_ACK; nxt_o = ST_M;
              end
              default: ;
            endcase
          end
          default: begin  // writeback ack
            if (st_i == ST_MI) nxt_o = ST_I;
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
  import mlc_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_req_valid_i,
  input  logic [1:0]        in_req_type_i,
  input  logic [LINE_W-1:0] in_req_line_i,
  output logic              in_req_ready_o,
  input  logic              ext_req_valid_i,
  input  logic [1:0]        ext_req_type_i,
  input  logic [LINE_W-1:0] ext_req_line_i,
  output logic              ext_req_ready_o,
  input  logic              ext_rsp_valid_i,
  input  logic [1:0]        ext_rsp_type_i,
  input  logic [LINE_W-1:0] ext_rsp_line_i,
  output logic              out_valid_o,
  output logic [2:0]        out_type_o,
  output logic [LINE_W-1:0] out_line_o,
  output logic              in_rsp_valid_o,
  output logic [1:0]        in_rsp_class_o,
  output logic [LINE_W-1:0] in_rsp_line_o,
  output logic              in_recall_valid_o,
  output logic [LINE_W-1:0] in_recall_line_o
);
  line_st_e          rsp_st, ext_st, in_st, sel_st, nxt_st;
  ev_kind_e          ev_kind;
  logic [1:0]        sel_type;
  logic [LINE_W-1:0] sel_line;
  logic              nx_out_v, nx_inr_v, nx_rcl_v;
  out_type_e         nx_out_t;
  in_class_e         nx_inr_c;

  mlc_state_table #(.LINE_W(LINE_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ev_kind != EV_NONE),
    .waddr_i   (sel_line),
    .wdata_i   (nxt_st),
    .raddr_a_i (ext_rsp_line_i),
    .raddr_b_i (ext_req_line_i),
    .raddr_c_i (in_req_line_i),
    .rdata_a_o (rsp_st),
    .rdata_b_o (ext_st),
    .rdata_c_o (in_st)
  );

  mlc_arbiter u_arb (
    .rsp_valid_i  (ext_rsp_valid_i),
    .oreq_valid_i (ext_req_valid_i),
    .oreq_st_i    (ext_st),
    .ireq_valid_i (in_req_valid_i),
    .ireq_type_i  (in_req_type_i),
    .ireq_st_i    (in_st),
    .oreq_ready_o (ext_req_ready_o),
    .ireq_ready_o (in_req_ready_o),
    .kind_o       (ev_kind)
  );

  always_comb begin
    case (ev_kind)
      EV_ORSP: begin sel_line = ext_rsp_line_i; sel_st = rsp_st; sel_type = ext_rsp_type_i; end
      EV_OREQ: begin sel_line = ext_req_line_i; sel_st = ext_st; sel_type = ext_req_type_i; end
      default: begin sel_line = in_req_line_i;  sel_st = in_st;  sel_type = in_req_type_i;  end
    endcase
  end

  mlc_next u_next (
    .kind_i  (ev_kind),
    .st_i    (sel_st),
    .typ_i   (sel_type),
    .nxt_o   (nxt_st),
    .out_v_o (nx_out_v),
    .out_t_o (nx_out_t),
    .inr_v_o (nx_inr_v),
    .inr_c_o (nx_inr_c),
    .rcl_v_o (nx_rcl_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o       <= 1'b0;
      out_type_o        <= '0;
      out_line_o        <= '0;
      in_rsp_valid_o    <= 1'b0;
      in_rsp_class_o    <= '0;
      in_rsp_line_o     <= '0;
      in_recall_valid_o <= 1'b0;
      in_recall_line_o  <= '0;
    end else begin
      out_valid_o       <= nx_out_v;
      out_type_o        <= nx_out_t;
      out_line_o        <= sel_line;
      in_rsp_valid_o    <= nx_inr_v;
      in_rsp_class_o    <= nx_inr_c;
      in_rsp_line_o     <= sel_line;
      in_recall_valid_o <= nx_rcl_v;
      in_recall_line_o  <= sel_line;
    end
  end

  // R3
  inv_ack_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_kind == EV_OREQ && ext_req_type_i == OREQ_INV && (ext_st == ST_IS || ext_st == ST_ISI))
    |=> (out_valid_o && out_type_o == OUT_INV_ACK));

  // R5
  stale_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rsp_valid_o && in_rsp_class_o == CLS_STALE)
    |-> $past(ev_kind == EV_ORSP && rsp_st == ST_ISI));

  // R7
  excl_unblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_kind == EV_ORSP && ext_rsp_type_i == ORSP_DATA_EXCL && (rsp_st == ST_IS || rsp_st == ST_ISI))
    |=> (out_valid_o && out_type_o == OUT_EXCL_UNBLOCK && in_rsp_valid_o && in_rsp_class_o == CLS_EXCL));

  // R9
  oreq_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_valid_i && !ext_rsp_valid_i && (ext_st == ST_IS || ext_st == ST_ISI))
    |-> ext_req_ready_o);

  // R12
  recall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_recall_valid_o |-> $past(ev_kind == EV_OREQ));

endmodule

// File: tb/tb_mlc_line_ctrl.sv
`timescale 1ns/1ps
module tb_mlc_line_ctrl;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic in_req_valid_i, ext_req_valid_i, ext_rsp_valid_i;
  logic [1:0] in_req_type_i, ext_req_type_i, ext_rsp_type_i;
  logic [LW-1:0] in_req_line_i, ext_req_line_i, ext_rsp_line_i;
  logic in_req_ready_o, ext_req_ready_o;
  logic out_valid_o, in_rsp_valid_o, in_recall_valid_o;
  logic [2:0] out_type_o;
  logic [1:0] in_rsp_class_o;
  logic [LW-1:0] out_line_o, in_rsp_line_o, in_recall_line_o;

  mlc_line_ctrl #(.LINE_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_req_valid_i(in_req_valid_i), .in_req_type_i(in_req_type_i),
    .in_req_line_i(in_req_line_i), .in_req_ready_o(in_req_ready_o),
    .ext_req_valid_i(ext_req_valid_i), .ext_req_type_i(ext_req_type_i),
    .ext_req_line_i(ext_req_line_i), .ext_req_ready_o(ext_req_ready_o),
    .ext_rsp_valid_i(ext_rsp_valid_i), .ext_rsp_type_i(ext_rsp_type_i),
    .ext_rsp_line_i(ext_rsp_line_i),
    .out_valid_o(out_valid_o), .out_type_o(out_type_o), .out_line_o(out_line_o),
    .in_rsp_valid_o(in_rsp_valid_o), .in_rsp_class_o(in_rsp_class_o),
    .in_rsp_line_o(in_rsp_line_o),
    .in_recall_valid_o(in_recall_valid_o), .in_recall_line_o(in_recall_line_o)
  );

  // codes
  localparam int LOAD = 0, STORE = 1, REPL = 2, RACK = 3;
  localparam int INV = 0, FGETS = 1, FGETX = 2;
  localparam int DATA = 0, PEER = 1, EXCL = 2, WBACK = 3;
  localparam int O_GETS = 0, O_GETX = 1, O_PUTX = 2, O_IACK = 3, O_UNBL = 4, O_XUNBL = 5, O_DATA = 6;
  localparam int C_SH = 0, C_EX = 1, C_ACK = 2, C_STALE = 3;

  int checks = 0;
  int errors = 0;
  string cur = "R1";

  int q_ot[$]; int q_ol[$]; string q_or[$];
  int q_ic[$]; int q_il[$]; string q_ir[$];
  int q_rl[$]; string q_rr[$];
  int t_e, l_e; string r_e;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic void exp_out(int t, int l);
    q_ot.push_back(t); q_ol.push_back(l); q_or.push_back(cur);
  endfunction
  function automatic void exp_inr(int c, int l);
    q_ic.push_back(c); q_il.push_back(l); q_ir.push_back(cur);
  endfunction
  function automatic void exp_rcl(int l);
    q_rl.push_back(l); q_rr.push_back(cur);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid_o) begin
        if (q_ot.size() == 0) chk(1'b0, cur, "unexpected outward type", int'(out_type_o), -1);
        else begin
          t_e = q_ot.pop_front(); l_e = q_ol.pop_front(); r_e = q_or.pop_front();
          chk(int'(out_type_o) == t_e, r_e, "outward type", int'(out_type_o), t_e);
          chk(int'(out_line_o) == l_e, r_e, "outward line", int'(out_line_o), l_e);
        end
      end
      if (in_rsp_valid_o) begin
        if (q_ic.size() == 0) chk(1'b0, cur, "unexpected inward class", int'(in_rsp_class_o), -1);
        else begin
          t_e = q_ic.pop_front(); l_e = q_il.pop_front(); r_e = q_ir.pop_front();
          chk(int'(in_rsp_class_o) == t_e, r_e, "inward class", int'(in_rsp_class_o), t_e);
          chk(int'(in_rsp_line_o) == l_e, r_e, "inward line", int'(in_rsp_line_o), l_e);
        end
      end
      if (in_recall_valid_o) begin
        if (q_rl.size() == 0) chk(1'b0, cur, "unexpected recall", int'(in_recall_line_o), -1);
        else begin
          l_e = q_rl.pop_front(); r_e = q_rr.pop_front();
          chk(int'(in_recall_line_o) == l_e, r_e, "recall line", int'(in_recall_line_o), l_e);
        end
      end
    end
  end

  task automatic inner(int t, int l, bit rdy);
    @(negedge clk);
    in_req_valid_i = 1'b1; in_req_type_i = 2'(t); in_req_line_i = LW'(l);
    #1;
    chk(in_req_ready_o == rdy, cur, "inner ready", int'(in_req_ready_o), int'(rdy));
    @(posedge clk); #1;
    in_req_valid_i = 1'b0;
  endtask

  task automatic ext(int t, int l, bit rdy);
    @(negedge clk);
    ext_req_valid_i = 1'b1; ext_req_type_i = 2'(t); ext_req_line_i = LW'(l);
    #1;
    chk(ext_req_ready_o == rdy, cur, "outer ready", int'(ext_req_ready_o), int'(rdy));
    @(posedge clk); #1;
    ext_req_valid_i = 1'b0;
  endtask

  task automatic rsp(int t, int l);
    @(negedge clk);
    ext_rsp_valid_i = 1'b1; ext_rsp_type_i = 2'(t); ext_rsp_line_i = LW'(l);
    @(posedge clk); #1;
    ext_rsp_valid_i = 1'b0;
  endtask

  // all three sources in one cycle
  task automatic conc(bit rv, int rt, int rl, int et, int el, int it, int il,
                      bit erdy, bit irdy);
    @(negedge clk);
    ext_rsp_valid_i = rv; ext_rsp_type_i = 2'(rt); ext_rsp_line_i = LW'(rl);
    ext_req_valid_i = 1'b1; ext_req_type_i = 2'(et); ext_req_line_i = LW'(el);
    in_req_valid_i = 1'b1; in_req_type_i = 2'(it); in_req_line_i = LW'(il);
    #1;
    chk(ext_req_ready_o == erdy, cur, "outer ready under contention", int'(ext_req_ready_o), int'(erdy));
    chk(in_req_ready_o == irdy, cur, "inner ready under contention", int'(in_req_ready_o), int'(irdy));
    @(posedge clk); #1;
    ext_rsp_valid_i = 1'b0; ext_req_valid_i = 1'b0; in_req_valid_i = 1'b0;
  endtask

  task automatic run_all();
    in_req_valid_i = 0; ext_req_valid_i = 0; ext_rsp_valid_i = 0;
    in_req_type_i = 0; ext_req_type_i = 0; ext_rsp_type_i = 0;
    in_req_line_i = 0; ext_req_line_i = 0; ext_rsp_line_i = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!out_valid_o && !in_rsp_valid_o && !in_recall_valid_o, "R1", "outputs idle in reset",
        int'(out_valid_o | in_rsp_valid_o | in_recall_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_valid_o, "R1", "out idle after reset", int'(out_valid_o), 0);

    cur = "R2";
    exp_out(O_GETS, 1); inner(LOAD, 1, 1);
    cur = "R8"; inner(LOAD, 1, 0);

    cur = "R3";
    exp_out(O_IACK, 1); ext(INV, 1, 1);
    exp_out(O_IACK, 1); ext(INV, 1, 1);
    cur = "R8"; inner(LOAD, 1, 0);

    cur = "R5";
    exp_inr(C_STALE, 1); rsp(DATA, 1);
    exp_out(O_GETS, 1); inner(LOAD, 1, 1);
    cur = "R4";
    exp_inr(C_SH, 1); rsp(DATA, 1);
    exp_inr(C_SH, 1); inner(LOAD, 1, 1);

    cur = "R6";
    exp_out(O_GETS, 2); inner(LOAD, 2, 1);
    exp_out(O_IACK, 2); ext(INV, 2, 1);
    exp_out(O_UNBL, 2); exp_inr(C_STALE, 2); rsp(PEER, 2);
    exp_out(O_GETS, 2); inner(LOAD, 2, 1);
    exp_out(O_UNBL, 2); exp_inr(C_SH, 2); rsp(PEER, 2);

    cur = "R7";
    exp_out(O_GETS, 3); inner(LOAD, 3, 1);
    exp_out(O_IACK, 3); ext(INV, 3, 1);
    exp_out(O_XUNBL, 3); exp_inr(C_EX, 3); rsp(EXCL, 3);
    exp_inr(C_EX, 3); inner(LOAD, 3, 1);
    exp_inr(C_EX, 3); inner(STORE, 3, 1);

    cur = "R11";
    exp_out(O_PUTX, 3); inner(REPL, 3, 1);
    inner(LOAD, 3, 0);
    rsp(WBACK, 3);
    exp_out(O_GETS, 3); inner(LOAD, 3, 1);
    exp_inr(C_SH, 3); rsp(DATA, 3);
    inner(REPL, 3, 1);
    exp_out(O_GETS, 3); inner(LOAD, 3, 1);
    exp_inr(C_SH, 3); rsp(DATA, 3);

    cur = "R10";
    exp_out(O_GETX, 4); inner(STORE, 4, 1);
    inner(LOAD, 4, 0);
    exp_out(O_XUNBL, 4); exp_inr(C_EX, 4); rsp(EXCL, 4);
    exp_out(O_GETX, 1); inner(STORE, 1, 1);
    inner(LOAD, 1, 0);
    exp_out(O_XUNBL, 1); exp_inr(C_ACK, 1); rsp(EXCL, 1);

    cur = "R12";
    exp_rcl(4); ext(FGETS, 4, 1);
    cur = "R9"; ext(INV, 4, 0);
    cur = "R8"; inner(LOAD, 4, 0);
    cur = "R12";
    exp_out(O_DATA, 4); inner(RACK, 4, 1);
    exp_inr(C_SH, 4); inner(LOAD, 4, 1);
    exp_rcl(4); ext(INV, 4, 1);
    exp_out(O_IACK, 4); inner(RACK, 4, 1);
    exp_out(O_GETS, 4); inner(LOAD, 4, 1);
    exp_inr(C_SH, 4); rsp(DATA, 4);
    exp_rcl(1); ext(FGETX, 1, 1);
    exp_out(O_DATA, 1); inner(RACK, 1, 1);
    exp_out(O_GETS, 1); inner(LOAD, 1, 1);
    exp_inr(C_SH, 1); rsp(DATA, 1);
    exp_out(O_IACK, 6); ext(INV, 6, 1);

    cur = "R13";
    exp_out(O_GETS, 5); inner(LOAD, 5, 1);
    exp_inr(C_SH, 5); conc(1'b1, DATA, 5, INV, 6, LOAD, 7, 1'b0, 1'b0);
    exp_out(O_IACK, 6); conc(1'b0, DATA, 0, INV, 6, LOAD, 0, 1'b1, 1'b0);
    exp_out(O_GETS, 7); inner(LOAD, 7, 1);
    exp_inr(C_SH, 7); rsp(DATA, 7);

    repeat (3) @(negedge clk);
    cur = "R1";
    chk(q_ot.size() == 0, "R1", "outward messages missing", q_ot.size(), 0);
    chk(q_ic.size() == 0, "R1", "inward messages missing", q_ic.size(), 0);
    chk(q_rl.size() == 0, "R12", "recalls missing", q_rl.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule